// File: doc/BRIEF.md
# Tag-Owned Speculative Register File

This block keeps two copies of sixteen 64-bit architectural registers, plus eight 64-bit scratch registers. The speculative copy always holds the newest value produced for each register. The committed copy holds only values whose producing operations have retired. Each speculative entry also carries a ready bit and an owner tag. The owner tag names the in-flight operation that will produce the entry's next value.

Dispatch lanes read their source operands from the speculative copy. A lane that writes a register claims it: the lane's tag becomes the entry's owner and the entry's ready bit is cleared. A result that completes later lands in the speculative copy only if its tag still owns the entry. A result from an older operation, whose register has since been claimed by a younger one, is dropped. Retiring operations write the committed copy. A recover pulse replaces the whole speculative copy with the committed copy in one cycle.

Lane numbers give age: a higher lane in the same cycle is younger. All read ports are combinational. Dispatch, completion, retirement and recover all take effect at the next clock edge.

Top module: `tagged_future_rf`

## Requirements
- R1: After reset, every register at source index 0..31 reads value 0, ready 1 and tag 0.
- R2: A dispatch lane with `disp_vld` and `disp_wr` set claims register `disp_dst`. From the next cycle, sources reading that register see ready 0 and the claiming lane's tag.
- R3: A completion writes `cmp_data` into the speculative entry and sets ready, visible from the next cycle, only when the entry is owned and its stored tag equals `cmp_tag`. The stored tag is kept.
- R4: A completion to an entry that is unowned, or whose stored tag differs from `cmp_tag`, leaves the value, ready bit and tag unchanged.
- R5: When several lanes claim the same register in one cycle, the highest-numbered lane becomes the owner.
- R6: A source in lane k that reads a register claimed in the same cycle by a lower lane j < k sees ready 0 and the tag of the highest such lane. Claims made by lane k itself or by higher lanes do not affect lane k's sources.
- R7: A claim and a matching completion to the same register in the same cycle leave the entry claimed by the new tag, with ready 0.
- R8: A retirement writes `ret_data` into the committed copy at `ret_dst`. Index 0..15 selects an architectural register and 16..23 a scratch register. Several retirements to one index in a cycle resolve to the highest port. Retirement does not change the speculative copy.
- R9: On recover, from the next cycle every architectural register reads its committed value, including same-cycle retirements, with ready 1, tag 0 and no owner. Same-cycle claims and completions are discarded.
- R10: Source indices 16..23 read the scratch copy with ready 1 and tag 0, and recover leaves them unchanged. Indices 24..31 read 0 with ready 1 and tag 0, and retirements to them are ignored.
- R11: Source reads show the state held at the start of the cycle. A completion in the same cycle is not bypassed to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | DISP_LANES | Lane carries an operation this cycle |
| disp_wr | input | DISP_LANES | Operation writes a register |
| disp_dst | input | DISP_LANES x 4 | Destination register 0..15 |
| disp_tag | input | DISP_LANES x TAG_W | Tag of the dispatching operation |
| src_idx | input | DISP_LANES x SRCS_PER_LANE x 5 | Source index 0..31 |
| src_val | output | DISP_LANES x SRCS_PER_LANE x DATA_W | Source value |
| src_rdy | output | DISP_LANES x SRCS_PER_LANE | Source value is final |
| src_tag | output | DISP_LANES x SRCS_PER_LANE x TAG_W | Tag to wait for when not ready |
| cmp_vld | input | CMPL_PORTS | Completion valid |
| cmp_dst | input | CMPL_PORTS x 4 | Completing register 0..15 |
| cmp_tag | input | CMPL_PORTS x TAG_W | Completing operation's tag |
| cmp_data | input | CMPL_PORTS x DATA_W | Completed result |
| ret_vld | input | RET_PORTS | Retirement valid |
| ret_dst | input | RET_PORTS x 5 | Committed index 0..23 |
| ret_data | input | RET_PORTS x DATA_W | Retired result |
| recover | input | 1 | Restore the speculative copy from the committed copy |

## Verification
The ownership rule is tried with four patterns:
- A claim followed by its own completion, which shows that matching results are accepted.
- Two claims in a row on one register with the older result arriving late, which shows that stale results are dropped.
- Two lanes claiming the same register in one cycle, which shows that lane order decides the owner.
- A completion aimed at a register that was never claimed, which shows that the owned bit, and not the tag value alone, gates writes.

Same-cycle patterns cover the cases where a combinational path or a priority could go wrong. Lane-to-lane claims show that forwarding reaches only higher lanes. A claim racing a completion shows which of the two wins. A recover racing a retirement shows that the newest committed value is copied. Scratch and out-of-range indices are read before and after recover to show that they stay outside the speculative state.

// File: rtl/tfrf_pkg.sv
package tfrf_pkg;
    localparam int ARCH_REGS    = 16;
    localparam int SCRATCH_REGS = 8;
    localparam int TOTAL_IDX    = ARCH_REGS + SCRATCH_REGS;
    localparam int ARCH_IDX_W   = $clog2(ARCH_REGS);
    localparam int SCR_IDX_W    = $clog2(SCRATCH_REGS);
    localparam int SRC_IDX_W    = $clog2(TOTAL_IDX);
endpackage

// File: rtl/tfrf_retire_merge.sv
// Folds this cycle's retirements into the committed and scratch copies.
module tfrf_retire_merge import tfrf_pkg::*; #(
    parameter int DATA_W    = 64,
    parameter int RET_PORTS = 3
) (
    input  logic [ARCH_REGS-1:0][DATA_W-1:0]    arch_cur,
    input  logic [SCRATCH_REGS-1:0][DATA_W-1:0] scr_cur,
    input  logic [RET_PORTS-1:0]                ret_vld,
    input  logic [RET_PORTS-1:0][SRC_IDX_W-1:0] ret_dst,
    input  logic [RET_PORTS-1:0][DATA_W-1:0]    ret_data,
    output logic [ARCH_REGS-1:0][DATA_W-1:0]    arch_nxt,
    output logic [SCRATCH_REGS-1:0][DATA_W-1:0] scr_nxt
);
    localparam logic [SRC_IDX_W-1:0] ARCH_LIM = SRC_IDX_W'(ARCH_REGS);
    localparam logic [SRC_IDX_W-1:0] TOT_LIM  = SRC_IDX_W'(TOTAL_IDX);

    always_comb begin
        arch_nxt = arch_cur;
        scr_nxt  = scr_cur;
        // ascending port order: the highest port wins (R8)
        for (int p = 0; p < RET_PORTS; p++) begin
            if (ret_vld[p]) begin
                if (ret_dst[p] < ARCH_LIM) begin
                    arch_nxt[ret_dst[p][ARCH_IDX_W-1:0]] = ret_data[p];
                end else if (ret_dst[p] < TOT_LIM) begin
                    scr_nxt[SCR_IDX_W'(ret_dst[p] - ARCH_LIM)] = ret_data[p];
                end
            end
        end
    end
endmodule

// File: rtl/tfrf_src_port.sv
// One source read port: speculative entry, same-cycle claims from lower lanes, scratch.
module tfrf_src_port import tfrf_pkg::*; #(
    parameter int DATA_W     = 64,
    parameter int TAG_W      = 8,
    parameter int DISP_LANES = 3
) (
    input  logic [SRC_IDX_W-1:0]                  idx,
    input  logic [ARCH_REGS-1:0][DATA_W-1:0]      spec_val,
    input  logic [ARCH_REGS-1:0]                  spec_rdy,
    input  logic [ARCH_REGS-1:0][TAG_W-1:0]       spec_tag,
    input  logic [SCRATCH_REGS-1:0][DATA_W-1:0]   scr_val,
    input  logic [DISP_LANES-1:0]                 lower_claim,
    input  logic [DISP_LANES-1:0][ARCH_IDX_W-1:0] claim_dst,
    input  logic [DISP_LANES-1:0][TAG_W-1:0]      claim_tag,
    output logic [DATA_W-1:0]                     val,
    output logic                                  rdy,
    output logic [TAG_W-1:0]                      tag
);
    localparam logic [SRC_IDX_W-1:0] ARCH_LIM = SRC_IDX_W'(ARCH_REGS);
    localparam logic [SRC_IDX_W-1:0] TOT_LIM  = SRC_IDX_W'(TOTAL_IDX);

    logic [ARCH_IDX_W-1:0] a_idx;
    assign a_idx = idx[ARCH_IDX_W-1:0];

    always_comb begin
        val = '0;
        rdy = 1'b1;
        tag = '0;
        if (idx < ARCH_LIM) begin
            val = spec_val[a_idx];
            rdy = spec_rdy[a_idx];
            tag = spec_tag[a_idx];
            // lower_claim is pre-masked to lanes older than this one (R6)
            for (int j = 0; j < DISP_LANES; j++) begin
                if (lower_claim[j] && claim_dst[j] == a_idx) begin
                    rdy = 1'b0;
                    tag = claim_tag[j];
                end
            end
        end else if (idx < TOT_LIM) begin
            val = scr_val[SCR_IDX_W'(idx - ARCH_LIM)];
        end
    end
endmodule

// File: rtl/tagged_future_rf.sv
module tagged_future_rf import tfrf_pkg::*; #(
    parameter int DATA_W        = 64,
    parameter int TAG_W         = 8,
    parameter int DISP_LANES    = 3,
    parameter int SRCS_PER_LANE = 3,
    parameter int CMPL_PORTS    = 3,
    parameter int RET_PORTS     = 3
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [DISP_LANES-1:0]                               disp_vld,
    input  logic [DISP_LANES-1:0]                               disp_wr,
    input  logic [DISP_LANES-1:0][ARCH_IDX_W-1:0]               disp_dst,
    input  logic [DISP_LANES-1:0][TAG_W-1:0]                    disp_tag,
    input  logic [DISP_LANES-1:0][SRCS_PER_LANE-1:0][SRC_IDX_W-1:0] src_idx,
    output logic [DISP_LANES-1:0][SRCS_PER_LANE-1:0][DATA_W-1:0]    src_val,
    output logic [DISP_LANES-1:0][SRCS_PER_LANE-1:0]                src_rdy,
    output logic [DISP_LANES-1:0][SRCS_PER_LANE-1:0][TAG_W-1:0]     src_tag,
    input  logic [CMPL_PORTS-1:0]                               cmp_vld,
    input  logic [CMPL_PORTS-1:0][ARCH_IDX_W-1:0]               cmp_dst,
    input  logic [CMPL_PORTS-1:0][TAG_W-1:0]                    cmp_tag,
    input  logic [CMPL_PORTS-1:0][DATA_W-1:0]                   cmp_data,
    input  logic [RET_PORTS-1:0]                                ret_vld,
    input  logic [RET_PORTS-1:0][SRC_IDX_W-1:0]                 ret_dst,
    input  logic [RET_PORTS-1:0][DATA_W-1:0]                    ret_data,
    input  logic                                                recover
);
    typedef struct packed {
        logic [ARCH_REGS-1:0][DATA_W-1:0]    arch;
        logic [ARCH_REGS-1:0][DATA_W-1:0]    spec;
        logic [ARCH_REGS-1:0]                rdy;
        logic [ARCH_REGS-1:0]                own;
        logic [ARCH_REGS-1:0][TAG_W-1:0]     tag;
        logic [SCRATCH_REGS-1:0][DATA_W-1:0] scr;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [ARCH_REGS-1:0][DATA_W-1:0]    arch_nxt;
    logic [SCRATCH_REGS-1:0][DATA_W-1:0] scr_nxt;
    logic [DISP_LANES-1:0]               claim;

    assign claim = disp_vld & disp_wr;

    tfrf_retire_merge #(
        .DATA_W    (DATA_W),
        .RET_PORTS (RET_PORTS)
    ) u_retire (
        .arch_cur (st_q.arch),
        .scr_cur  (st_q.scr),
        .ret_vld  (ret_vld),
        .ret_dst  (ret_dst),
        .ret_data (ret_data),
        .arch_nxt (arch_nxt),
        .scr_nxt  (scr_nxt)
    );

    for (genvar l = 0; l < DISP_LANES; l++) begin : g_lane
        localparam logic [DISP_LANES-1:0] LOW_MASK = DISP_LANES'((1 << l) - 1);
        logic [DISP_LANES-1:0] lower_claim;
        assign lower_claim = claim & LOW_MASK;
        for (genvar s = 0; s < SRCS_PER_LANE; s++) begin : g_src
            tfrf_src_port #(
                .DATA_W     (DATA_W),
                .TAG_W      (TAG_W),
                .DISP_LANES (DISP_LANES)
            ) u_rd (
                .idx         (src_idx[l][s]),
                .spec_val    (st_q.spec),
                .spec_rdy    (st_q.rdy),
                .spec_tag    (st_q.tag),
                .scr_val     (st_q.scr),
                .lower_claim (lower_claim),
                .claim_dst   (disp_dst),
                .claim_tag   (disp_tag),
                .val         (src_val[l][s]),
                .rdy         (src_rdy[l][s]),
                .tag         (src_tag[l][s])
            );
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.arch = arch_nxt;
        st_d.scr  = scr_nxt;
        // completions: accepted only by the current owner (R3, R4)
        for (int c = 0; c < CMPL_PORTS; c++) begin
            if (cmp_vld[c] && st_q.own[cmp_dst[c]] && st_q.tag[cmp_dst[c]] == cmp_tag[c]) begin
                st_d.spec[cmp_dst[c]] = cmp_data[c];
                st_d.rdy[cmp_dst[c]]  = 1'b1;
            end
        end
        // claims after completions, youngest lane last (R5, R7)
        for (int l = 0; l < DISP_LANES; l++) begin
            if (claim[l]) begin
                st_d.rdy[disp_dst[l]] = 1'b0;
                st_d.own[disp_dst[l]] = 1'b1;
                st_d.tag[disp_dst[l]] = disp_tag[l];
            end
        end
        // recover overrides everything speculative (R9)
        if (recover) begin
            st_d.spec = arch_nxt;
            st_d.rdy  = '1;
            st_d.own  = '0;
            st_d.tag  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tfrf_checker.sv
module tfrf_checker import tfrf_pkg::*; #(
    parameter int DATA_W     = 64,
    parameter int TAG_W      = 8,
    parameter int DISP_LANES = 3,
    parameter int CMPL_PORTS = 3
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  recover,
    input logic [DISP_LANES-1:0]                 disp_vld,
    input logic [DISP_LANES-1:0]                 disp_wr,
    input logic [DISP_LANES-1:0][ARCH_IDX_W-1:0] disp_dst,
    input logic [DISP_LANES-1:0][TAG_W-1:0]      disp_tag,
    input logic [CMPL_PORTS-1:0]                 cmp_vld,
    input logic [CMPL_PORTS-1:0][ARCH_IDX_W-1:0] cmp_dst,
    input logic [CMPL_PORTS-1:0][TAG_W-1:0]      cmp_tag,
    input logic [DATA_W-1:0]                     cmp_data0,
    input logic [SRC_IDX_W-1:0]                  rd_idx,
    input logic [DATA_W-1:0]                     rd_val,
    input logic                                  rd_rdy,
    input logic [TAG_W-1:0]                      rd_tag,
    input logic [SRC_IDX_W-1:0]                  fw_idx,
    input logic                                  fw_rdy,
    input logic [TAG_W-1:0]                      fw_tag,
    input logic [SRC_IDX_W-1:0]                  sc_idx,
    input logic                                  sc_rdy,
    input logic [TAG_W-1:0]                      sc_tag
);
    localparam logic [SRC_IDX_W-1:0] ARCH_LIM = SRC_IDX_W'(ARCH_REGS);

    logic             live_q;
    logic             claim0, fw_hit, r_claimed, match_cmp, other_cmp, hold, wr_ok;
    logic [TAG_W-1:0] win_tag, fw_exp_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    always_comb begin
        claim0  = disp_vld[0] && disp_wr[0];
        win_tag = disp_tag[0];
        for (int j = 0; j < DISP_LANES; j++)
            if (disp_vld[j] && disp_wr[j] && disp_dst[j] == disp_dst[0]) win_tag = disp_tag[j];
        fw_hit     = 1'b0;
        fw_exp_tag = '0;
        for (int j = 0; j < DISP_LANES - 1; j++)
            if (disp_vld[j] && disp_wr[j] && SRC_IDX_W'(disp_dst[j]) == fw_idx) begin
                fw_hit     = 1'b1;
                fw_exp_tag = disp_tag[j];
            end
        r_claimed = 1'b0;
        for (int j = 0; j < DISP_LANES; j++)
            if (disp_vld[j] && disp_wr[j] && SRC_IDX_W'(disp_dst[j]) == rd_idx) r_claimed = 1'b1;
        match_cmp = 1'b0;
        other_cmp = 1'b0;
        for (int c = 0; c < CMPL_PORTS; c++)
            if (cmp_vld[c] && SRC_IDX_W'(cmp_dst[c]) == rd_idx) begin
                if (cmp_tag[c] == rd_tag) match_cmp = 1'b1;
                if (c != 0) other_cmp = 1'b1;
            end
        hold  = (rd_idx < ARCH_LIM) && !rd_rdy && !recover && !r_claimed && !match_cmp;
        wr_ok = (rd_idx < ARCH_LIM) && !rd_rdy && !recover && !r_claimed && !other_cmp &&
                cmp_vld[0] && SRC_IDX_W'(cmp_dst[0]) == rd_idx && cmp_tag[0] == rd_tag;
    end

    p_claim_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(claim0 && !recover) && rd_idx == SRC_IDX_W'($past(disp_dst[0]))
        |-> !rd_rdy && rd_tag == $past(win_tag));

    p_match_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(wr_ok) && rd_idx == $past(rd_idx)
        |-> rd_rdy && rd_val == $past(cmp_data0));

    p_stale_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(hold) && rd_idx == $past(rd_idx)
        |-> !rd_rdy && rd_tag == $past(rd_tag));

    p_lane_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fw_hit |-> !fw_rdy && fw_tag == fw_exp_tag);

    p_recover_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(recover) && rd_idx < ARCH_LIM |-> rd_rdy && rd_tag == '0);

    p_scratch_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sc_idx >= ARCH_LIM |-> sc_rdy && sc_tag == '0);
endmodule

bind tagged_future_rf tfrf_checker #(
    .DATA_W     (DATA_W),
    .TAG_W      (TAG_W),
    .DISP_LANES (DISP_LANES),
    .CMPL_PORTS (CMPL_PORTS)
) u_tfrf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .recover   (recover),
    .disp_vld  (disp_vld),
    .disp_wr   (disp_wr),
    .disp_dst  (disp_dst),
    .disp_tag  (disp_tag),
    .cmp_vld   (cmp_vld),
    .cmp_dst   (cmp_dst),
    .cmp_tag   (cmp_tag),
    .cmp_data0 (cmp_data[0]),
    .rd_idx    (src_idx[0][0]),
    .rd_val    (src_val[0][0]),
    .rd_rdy    (src_rdy[0][0]),
    .rd_tag    (src_tag[0][0]),
    .fw_idx    (src_idx[DISP_LANES-1][0]),
    .fw_rdy    (src_rdy[DISP_LANES-1][0]),
    .fw_tag    (src_tag[DISP_LANES-1][0]),
    .sc_idx    (src_idx[0][SRCS_PER_LANE-1]),
    .sc_rdy    (src_rdy[0][SRCS_PER_LANE-1]),
    .sc_tag    (src_tag[0][SRCS_PER_LANE-1])
);

// File: tb/tb_tagged_future_rf.sv
`timescale 1ns/1ps
module tb_tagged_future_rf;
    import tfrf_pkg::*;
    localparam int DW = 64, TW = 8, NL = 3, NS = 3, NC = 3, NR = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NL-1:0]                 disp_vld, disp_wr;
    logic [NL-1:0][ARCH_IDX_W-1:0] disp_dst;
    logic [NL-1:0][TW-1:0]         disp_tag;
    logic [NL-1:0][NS-1:0][SRC_IDX_W-1:0] src_idx;
    logic [NL-1:0][NS-1:0][DW-1:0] src_val;
    logic [NL-1:0][NS-1:0]         src_rdy;
    logic [NL-1:0][NS-1:0][TW-1:0] src_tag;
    logic [NC-1:0]                 cmp_vld;
    logic [NC-1:0][ARCH_IDX_W-1:0] cmp_dst;
    logic [NC-1:0][TW-1:0]         cmp_tag;
    logic [NC-1:0][DW-1:0]         cmp_data;
    logic [NR-1:0]                 ret_vld;
    logic [NR-1:0][SRC_IDX_W-1:0]  ret_dst;
    logic [NR-1:0][DW-1:0]         ret_data;
    logic                          recover;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tagged_future_rf #(.DATA_W(DW), .TAG_W(TW), .DISP_LANES(NL), .SRCS_PER_LANE(NS),
                       .CMPL_PORTS(NC), .RET_PORTS(NR)) dut (.*);

    task automatic idle();
        disp_vld = '0; disp_wr = '0; disp_dst = '0; disp_tag = '0; src_idx = '0;
        cmp_vld = '0; cmp_dst = '0; cmp_tag = '0; cmp_data = '0;
        ret_vld = '0; ret_dst = '0; ret_data = '0; recover = 1'b0;
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic claim(int l, int r, logic [TW-1:0] t);
        disp_vld[l] = 1'b1; disp_wr[l] = 1'b1; disp_dst[l] = ARCH_IDX_W'(r); disp_tag[l] = t;
    endtask

    task automatic complete(int p, int r, logic [TW-1:0] t, logic [DW-1:0] d);
        cmp_vld[p] = 1'b1; cmp_dst[p] = ARCH_IDX_W'(r); cmp_tag[p] = t; cmp_data[p] = d;
    endtask

    task automatic retire(int p, int idx, logic [DW-1:0] d);
        ret_vld[p] = 1'b1; ret_dst[p] = SRC_IDX_W'(idx); ret_data[p] = d;
    endtask

    // read through lane 0, source 0; value only checked when ready is expected
    task automatic look(string req, int r, logic [DW-1:0] v, logic rdy, logic [TW-1:0] t);
        src_idx[0][0] = SRC_IDX_W'(r);
        #0.2;
        chk(req, $sformatf("r%0d rdy", r), 64'(src_rdy[0][0]), 64'(rdy));
        chk(req, $sformatf("r%0d tag", r), 64'(src_tag[0][0]), 64'(t));
        if (rdy) chk(req, $sformatf("r%0d val", r), src_val[0][0], v);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 32; r++) look("R1", r, '0, 1'b1, '0);
    endtask

    task automatic t_claim_complete();
        claim(0, 3, 8'd5); cyc();
        look("R2", 3, '0, 1'b0, 8'd5);
        complete(0, 3, 8'd5, 64'hA3A3);
        look("R11", 3, '0, 1'b0, 8'd5);
        cyc();
        look("R3", 3, 64'hA3A3, 1'b1, 8'd5);
    endtask

    task automatic t_stale();
        claim(0, 4, 8'd10); cyc();
        claim(0, 4, 8'd11); cyc();
        complete(1, 4, 8'd10, 64'hBAD0); cyc();
        look("R4", 4, '0, 1'b0, 8'd11);
        complete(2, 4, 8'd11, 64'h4444); cyc();
        look("R3", 4, 64'h4444, 1'b1, 8'd11);
        complete(0, 12, 8'd0, 64'hEEEE); cyc();
        look("R4", 12, '0, 1'b1, 8'd0);
    endtask

    task automatic t_same_cycle();
        claim(0, 5, 8'd20); claim(2, 5, 8'd22); cyc();
        look("R5", 5, '0, 1'b0, 8'd22);
        complete(0, 5, 8'd20, 64'h5555); cyc();
        look("R5", 5, '0, 1'b0, 8'd22);
    endtask

    task automatic t_intra();
        claim(0, 6, 8'd30); claim(1, 7, 8'd31);
        src_idx[1][0] = 5'd6; src_idx[2][1] = 5'd6; src_idx[2][2] = 5'd7;
        src_idx[0][2] = 5'd6; src_idx[1][1] = 5'd7;
        #0.2;
        chk("R6", "l1 sees l0 rdy", 64'(src_rdy[1][0]), 64'd0);
        chk("R6", "l1 sees l0 tag", 64'(src_tag[1][0]), 64'd30);
        chk("R6", "l2 sees l0 tag", 64'(src_tag[2][1]), 64'd30);
        chk("R6", "l2 sees l1 tag", 64'(src_tag[2][2]), 64'd31);
        chk("R6", "l0 own claim hidden", 64'(src_rdy[0][2]), 64'd1);
        chk("R6", "l1 own claim hidden", 64'(src_rdy[1][1]), 64'd1);
        cyc();
        claim(0, 8, 8'd32); claim(1, 8, 8'd33); src_idx[2][0] = 5'd8;
        #0.2;
        chk("R6", "highest lower lane", 64'(src_tag[2][0]), 64'd33);
        cyc();
    endtask

    task automatic t_claim_vs_complete();
        claim(0, 9, 8'd40); cyc();
        complete(0, 9, 8'd40, 64'h9999); claim(1, 9, 8'd41); cyc();
        look("R7", 9, '0, 1'b0, 8'd41);
    endtask

    task automatic t_retire_recover();
        retire(0, 3, 64'hC3C3); cyc();
        look("R8", 3, 64'hA3A3, 1'b1, 8'd5);
        retire(0, 10, 64'h1); retire(2, 10, 64'h2); cyc();
        retire(1, 11, 64'hB11); recover = 1'b1;
        claim(0, 13, 8'd50); complete(0, 3, 8'd5, 64'hFFFF);
        cyc();
        look("R9", 3, 64'hC3C3, 1'b1, '0);
        look("R8", 10, 64'h2, 1'b1, '0);
        look("R9", 11, 64'hB11, 1'b1, '0);
        look("R9", 13, '0, 1'b1, '0);
        look("R9", 4, '0, 1'b1, '0);
        complete(0, 4, 8'd11, 64'h7777); cyc();
        look("R9", 4, '0, 1'b1, '0);
    endtask

    task automatic t_scratch();
        retire(0, 18, 64'h5C5C); retire(1, 25, 64'hDDDD); cyc();
        look("R10", 18, 64'h5C5C, 1'b1, '0);
        look("R10", 25, '0, 1'b1, '0);
        recover = 1'b1; cyc();
        look("R10", 18, 64'h5C5C, 1'b1, '0);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_claim_complete();
        t_stale();
        t_same_cycle();
        t_intra();
        t_claim_vs_complete();
        t_retire_recover();
        t_scratch();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule